// File: doc/BRIEF.md
# Burst-Counted Serial Peripheral Master

This block is a serial peripheral interface master that software drives through a small register window. Software fills a transmit queue, picks a direction mode, programs how many byte frames the next burst carries and the serial clock divider, then sets the run bit. The shift engine sends 8-bit frames MSB first in clock mode 0 (clock idles low, data launched on the falling edge, sampled on the rising edge). It stops by itself once the programmed number of frames has shifted. Received frames collect in a receive queue that software drains through the data register.

Three direction modes exist. In full duplex every frame consumes a queued byte and stores the byte received. In send-only mode nothing is stored. In listen-only mode no queued data is needed, the data output stays low, and every received frame is stored. If the transmit queue runs dry in a mode that sends, the engine parks with the clock low until a byte arrives. The select line is a plain register bit, so the line stays asserted across every frame of a burst.

Top module: `spi_frame_master`

## Requirements
- R1: After reset: status reads 0x4, the divider reads 2, the frame register reads 0, the run register reads 0, cs_n is 1 and sclk is 0.
- R2: The threshold register at address 7 has a transmit field in bits [4:0] and a receive field in bits [12:8]. Both reset to 15, and it can be written at any time and read back.
- R3: Writes to the mode (address 1), frame (address 2) and divider (address 3) registers are ignored while the run bit (address 0, bit 0) is 1. Each register reads back its last accepted value.
- R4: Writing run=1 while run is 0 starts a burst of exactly FRAMES+1 frames. Busy (status bit 0) then stays 1 until the last frame has shifted completely.
- R5: Frames shift MSB first in clock mode 0. mosi is stable while sclk is high, and in full duplex each byte received on miso is stored in arrival order.
- R6: Within a frame the sclk period is DIV system clocks, with DIV/2 clocks high.
- R7: The first rising sclk edge of a frame comes DIV/2 clocks after the frame begins. With the transmit queue empty mid-burst in a sending mode, sclk stays low and busy stays 1 until a byte is pushed. The rising edge then follows DIV/2+1 clocks after the push edge.
- R8: In send-only mode (mode 1) no received frame is stored: status bit 2 (receive empty) stays 1.
- R9: In listen-only mode (mode 2) a burst runs with an empty transmit queue, mosi stays 0, and every received frame is stored.
- R10: Reading the data register (address 6) pops one received byte and returns it in bits [7:0] with all upper bits zero. Reading an empty queue returns 0.
- R11: cs_n is the inverse of bit 0 of the select register (address 4) and stays low across all frames of a burst.
- R12: Writing run=0 during a burst stops it at once: busy drops and sclk returns low with no further frames.
- R13: The transmit queue holds 32 bytes. Status bit 1 (transmit full) is set at 32 entries, and a push into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 6) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low slave select |

## Verification
The hardest state to reach is a burst parked mid-way because the transmit queue ran dry. The engine must hold the clock low while still reporting busy, and then resume with the correct setup delay. The stimulus queues one byte for a two-frame burst, waits well past the first frame, checks that the clock is idle and busy is still set, and then pushes the second byte. It measures the time from that push edge to the next rising clock edge. A second hard case is a push into a full queue. The bench fills 32 entries, pushes a marker byte that must be dropped, drains the queue with a burst, and then runs a one-byte burst whose contents would expose the marker if it had been kept.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

    localparam int FRAME_BITS = 8;
    localparam int BIT_IDX_W  = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        A_ENABLE = 3'd0,
        A_CTRL   = 3'd1,
        A_FRAMES = 3'd2,
        A_DIV    = 3'd3,
        A_SELECT = 3'd4,
        A_STATUS = 3'd5,
        A_DATA   = 3'd6,
        A_THRESH = 3'd7
    } reg_addr_e;

    // value 3 is reserved and behaves as full duplex
    typedef enum logic [1:0] {
        XM_TXRX   = 2'd0,
        XM_TXONLY = 2'd1,
        XM_RXONLY = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LOW,
        ST_HIGH
    } eng_state_e;

    typedef struct packed {
        logic rx_empty;
        logic tx_full;
        logic busy;
    } status_t;

    function automatic logic mode_sends(xfer_mode_e m);
        return m != XM_RXONLY;
    endfunction

    function automatic logic mode_keeps(xfer_mode_e m);
        return m != XM_TXONLY;
    endfunction

endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [AW:0]      count;
    logic             do_push, do_pop;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine
    import spi_fm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  abort,
    input  xfer_mode_e            mode,
    input  logic [CNT_W-1:0]      frames_m1,
    input  logic [DIV_W-1:0]      divider,
    input  logic                  tx_empty,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  tx_pop,
    input  logic                  rx_full,
    output logic                  rx_push,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso,
    output logic                  busy
);
    eng_state_e            state;
    logic [DIV_W-1:0]      timer;
    logic [DIV_W-1:0]      half;
    logic [BIT_IDX_W-1:0]  bitn;
    logic [CNT_W-1:0]      frame_idx;
    logic [FRAME_BITS-1:0] txsh, rxsh;
    logic                  need_tx, need_rx, can_go, half_done, frame_end;

    assign half      = ((divider >> 1) == '0) ? DIV_W'(1) : (divider >> 1);
    assign need_tx   = mode_sends(mode);
    assign need_rx   = mode_keeps(mode);
    assign can_go    = (state == ST_WAIT) && (!need_tx || !tx_empty) && (!need_rx || !rx_full);
    assign half_done = (timer == half - 1'b1);
    assign frame_end = (state == ST_HIGH) && half_done && (bitn == BIT_IDX_W'(FRAME_BITS - 1));

    assign tx_pop  = can_go && need_tx;
    assign rx_push = frame_end && need_rx;
    assign rx_data = rxsh;
    assign sclk    = (state == ST_HIGH);
    assign mosi    = ((state == ST_LOW) || (state == ST_HIGH)) && txsh[FRAME_BITS-1];
    assign busy    = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            timer     <= '0;
            bitn      <= '0;
            frame_idx <= '0;
            txsh      <= '0;
            rxsh      <= '0;
        end else if (abort) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_WAIT;
                    frame_idx <= '0;
                end
                ST_WAIT: if (can_go) begin
                    txsh  <= need_tx ? tx_data : '0;
                    timer <= '0;
                    bitn  <= '0;
                    state <= ST_LOW;
                end
                ST_LOW: if (half_done) begin
                    timer <= '0;
                    rxsh  <= {rxsh[FRAME_BITS-2:0], miso};
                    state <= ST_HIGH;
                end else begin
                    timer <= timer + 1'b1;
                end
                ST_HIGH: if (half_done) begin
                    timer <= '0;
                    if (frame_end) begin
                        if (frame_idx == frames_m1) begin
                            state <= ST_IDLE;
                        end else begin
                            frame_idx <= frame_idx + 1'b1;
                            state     <= ST_WAIT;
                        end
                    end else begin
                        bitn  <= bitn + 1'b1;
                        txsh  <= txsh << 1;
                        state <= ST_LOW;
                    end
                end else begin
                    timer <= timer + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
    import spi_fm_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 16,
    parameter int BUS_W      = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [BUS_W-1:0] reg_rdata,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic             cs_n
);
    localparam int              THR_W   = $clog2(FIFO_DEPTH);
    localparam int              RXT_LSB = 8;
    localparam logic [THR_W-1:0] THR_RST = THR_W'(FIFO_DEPTH / 2 - 1);

    reg_addr_e             a;
    logic                  en_q, sel_q;
    xfer_mode_e            mode_q;
    logic [CNT_W-1:0]      frames_q;
    logic [DIV_W-1:0]      div_q;
    logic [THR_W-1:0]      tx_thr_q, rx_thr_q;
    logic                  eng_start, eng_abort, eng_busy;
    logic                  tx_push, tx_pop, tx_full, tx_empty;
    logic                  rx_push, rx_pop, rx_full, rx_empty;
    logic [FRAME_BITS-1:0] tx_dout, rx_dout, rx_byte;
    status_t               st;
    logic                  unused_wdata;

    assign a            = reg_addr_e'(reg_addr);
    assign unused_wdata = &{1'b0, reg_wdata};
    assign eng_start    = reg_wr && (a == A_ENABLE) &&  reg_wdata[0] && !en_q;
    assign eng_abort    = reg_wr && (a == A_ENABLE) && !reg_wdata[0] &&  en_q;
    assign tx_push      = reg_wr && (a == A_DATA);
    assign rx_pop       = reg_rd && (a == A_DATA);
    assign cs_n         = ~sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            sel_q    <= 1'b0;
            mode_q   <= XM_TXRX;
            frames_q <= '0;
            div_q    <= DIV_W'(2);
            tx_thr_q <= THR_RST;
            rx_thr_q <= THR_RST;
        end else if (reg_wr) begin
            case (a)
                A_ENABLE: en_q   <= reg_wdata[0];
                A_CTRL:   if (!en_q) mode_q   <= xfer_mode_e'(reg_wdata[1:0]);
                A_FRAMES: if (!en_q) frames_q <= reg_wdata[CNT_W-1:0];
                A_DIV:    if (!en_q) div_q    <= reg_wdata[DIV_W-1:0];
                A_SELECT: sel_q  <= reg_wdata[0];
                A_THRESH: begin
                    tx_thr_q <= reg_wdata[THR_W-1:0];
                    rx_thr_q <= reg_wdata[RXT_LSB +: THR_W];
                end
                default: ;
            endcase
        end
    end

    spi_fm_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_txf (
        .clk(clk), .rst(rst), .push(tx_push), .din(reg_wdata[FRAME_BITS-1:0]),
        .pop(tx_pop), .dout(tx_dout), .full(tx_full), .empty(tx_empty)
    );

    spi_fm_fifo #(.WIDTH(FRAME_BITS), .DEPTH(FIFO_DEPTH)) u_rxf (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .full(rx_full), .empty(rx_empty)
    );

    spi_fm_engine #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst(rst), .start(eng_start), .abort(eng_abort),
        .mode(mode_q), .frames_m1(frames_q), .divider(div_q),
        .tx_empty(tx_empty), .tx_data(tx_dout), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_data(rx_byte),
        .sclk(sclk), .mosi(mosi), .miso(miso), .busy(eng_busy)
    );

    assign st = '{rx_empty: rx_empty, tx_full: tx_full, busy: eng_busy};

    always_comb begin
        reg_rdata = '0;
        case (a)
            A_ENABLE: reg_rdata[0]         = en_q;
            A_CTRL:   reg_rdata[1:0]       = mode_q;
            A_FRAMES: reg_rdata[CNT_W-1:0] = frames_q;
            A_DIV:    reg_rdata[DIV_W-1:0] = div_q;
            A_SELECT: reg_rdata[0]         = sel_q;
            A_STATUS: reg_rdata[2:0]       = st;
            A_DATA:   if (!rx_empty) reg_rdata[FRAME_BITS-1:0] = rx_dout;
            A_THRESH: begin
                reg_rdata[THR_W-1:0]         = tx_thr_q;
                reg_rdata[RXT_LSB +: THR_W]  = rx_thr_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_fm_chk.sv
module spi_fm_chk
    import spi_fm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en_q,
    input logic             busy,
    input logic             sclk,
    input logic             mosi,
    input logic             abort,
    input logic             tx_pop,
    input logic             rx_push,
    input xfer_mode_e       mode,
    input logic [CNT_W-1:0] frames_q,
    input logic [DIV_W-1:0] div_q
);
    // R3
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        en_q |=> ($stable(frames_q) && $stable(div_q) && $stable(mode)));

    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(sclk) || $past(abort)));

    // R5
    mosi_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(mosi));

    // R8
    txonly_nostore_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_TXONLY) |-> !rx_push);

    // R9
    rxonly_nopop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == XM_RXONLY) |-> !tx_pop);

    // R12
    busy_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> en_q);
endmodule

bind spi_frame_master spi_fm_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst(rst), .en_q(en_q), .busy(eng_busy), .sclk(sclk),
    .mosi(mosi), .abort(eng_abort), .tx_pop(tx_pop), .rx_push(rx_push),
    .mode(mode_q), .frames_q(frames_q), .div_q(div_q)
);

// File: tb/sim_spi_frame_master.sv
module sim_spi_frame_master;
    import spi_fm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, cs_n;
    logic        miso = 1'b0;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_mosi[$];
    logic [7:0] exp_rx[$];
    bit    chk_mosi = 1'b0, chk_timing = 1'b0, rx_on = 1'b0;
    int    exp_div = 2;
    int    n_frames = 0;
    time   t_last_wr = 0, last_rise = 0, first_rise = 0;

    always #4 clk = ~clk;

    spi_frame_master u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    function automatic logic [7:0] sbyte(int k);
        return 8'(8'hA7 ^ (k * 29));
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] ad, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ad; reg_wdata = d;
        @(posedge clk);
        t_last_wr = $time;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] ad, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = ad;
        #1 d = reg_rdata;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // driver: each queued byte becomes an expected serial frame
    task automatic push_tx(input logic [7:0] b);
        wr(A_DATA, {24'h0, b});
        exp_mosi.push_back(b);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = 32'h1;
        for (int i = 0; i < 4000 && s[0]; i++) rd(A_STATUS, s);
        chk(!s[0], "R4 burst completes", s[0], 0);
    endtask

    task automatic rd_expect(input string tag, input logic [31:0] e);
        logic [31:0] v;
        rd(A_DATA, v);
        chk(v == e, tag, v, e);
    endtask

    // monitor: serial slave that scoreboards every completed frame
    initial begin : slave
        logic [7:0] got, cur;
        int sbit, sframe;
        got = '0; sbit = 0; sframe = 0;
        cur = sbyte(0);
        miso = cur[7];
        forever begin
            @(posedge sclk or posedge cs_n);
            if (cs_n) begin
                sbit = 0;
                miso = cur[7];
            end else begin
                got = {got[6:0], mosi};
                if (sbit != 0 && chk_timing)
                    chk(($time - last_rise) == exp_div * 8, "R6 sclk period",
                        $time - last_rise, exp_div * 8);
                if (sbit == 0) first_rise = $time;
                last_rise = $time;
                sbit++;
                if (sbit == 8) begin
                    sbit = 0;
                    n_frames++;
                    if (chk_mosi) begin
                        if (exp_mosi.size() == 0) chk(1'b0, "R4 extra frame", got, 0);
                        else begin
                            logic [7:0] e;
                            e = exp_mosi.pop_front();
                            chk(got == e, "R5 mosi byte", got, e);
                        end
                    end
                    if (rx_on) exp_rx.push_back(cur);
                    sframe++;
                    cur = sbyte(sframe);
                end
                miso = cur[7 - sbit];
            end
        end
    end

    always @(negedge sclk) begin
        if (chk_timing)
            chk(($time - last_rise) == (exp_div / 2) * 8, "R6 high width",
                $time - last_rise, (exp_div / 2) * 8);
    end

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        int f0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_STATUS, v); chk(v == 32'h4, "R1 status", v, 32'h4);
        rd(A_DIV, v);    chk(v == 32'h2, "R1 divider", v, 2);
        rd(A_FRAMES, v); chk(v == 32'h0, "R1 frames", v, 0);
        rd(A_ENABLE, v); chk(v == 32'h0, "R1 run", v, 0);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 pins", {cs_n, sclk}, 2'b10);

        // R2 thresholds
        rd(A_THRESH, v); chk(v == 32'h0F0F, "R2 reset", v, 32'h0F0F);
        wr(A_THRESH, 32'h0305);
        rd(A_THRESH, v); chk(v == 32'h0305, "R2 readback", v, 32'h0305);

        // full duplex, 4 frames
        exp_div = 4;
        wr(A_DIV, 4); wr(A_CTRL, 0); wr(A_FRAMES, 3); wr(A_SELECT, 1);
        chk(cs_n == 1'b0, "R11 select", cs_n, 0);
        push_tx(8'h3C); push_tx(8'h81); push_tx(8'hFF); push_tx(8'h00);
        chk_mosi = 1; chk_timing = 1; rx_on = 1;
        f0 = n_frames;
        wr(A_ENABLE, 1);
        repeat (40) @(posedge clk);
        @(negedge clk) chk(cs_n == 1'b0, "R11 held mid-burst", cs_n, 0);
        wait_idle();
        chk(n_frames - f0 == 4, "R4 frame count", n_frames - f0, 4);
        chk(exp_mosi.size() == 0, "R5 all sent", exp_mosi.size(), 0);
        for (int i = 0; i < 4; i++) rd_expect("R10 rx byte", {24'h0, exp_rx.pop_front()});
        rd_expect("R10 empty read", 32'h0);
        rd(A_STATUS, v); chk(v[2] == 1'b1, "R10 empty flag", v, 32'h4);

        // R3 writes ignored while enabled
        wr(A_FRAMES, 7); wr(A_DIV, 8); wr(A_CTRL, 2);
        rd(A_FRAMES, v); chk(v == 3, "R3 frames held", v, 3);
        rd(A_DIV, v);    chk(v == 4, "R3 divider held", v, 4);
        rd(A_CTRL, v);   chk(v == 0, "R3 mode held", v, 0);
        wr(A_ENABLE, 0);
        wr(A_FRAMES, 7); wr(A_DIV, 8); wr(A_CTRL, 2);
        rd(A_FRAMES, v); chk(v == 7, "R3 frames taken", v, 7);
        rd(A_DIV, v);    chk(v == 8, "R3 divider taken", v, 8);
        rd(A_CTRL, v);   chk(v == 2, "R3 mode taken", v, 2);
        exp_div = 8;

        // R9 listen-only with empty transmit queue
        wr(A_FRAMES, 2);
        for (int i = 0; i < 3; i++) exp_mosi.push_back(8'h00);
        f0 = n_frames;
        wr(A_ENABLE, 1);
        wait_idle();
        chk(n_frames - f0 == 3, "R9 frames", n_frames - f0, 3);
        for (int i = 0; i < 3; i++) rd_expect("R9 stored byte", {24'h0, exp_rx.pop_front()});
        wr(A_ENABLE, 0);

        // R8 send-only
        wr(A_CTRL, 1); wr(A_FRAMES, 1); rx_on = 0;
        push_tx(8'hAA); push_tx(8'h55);
        wr(A_ENABLE, 1);
        wait_idle();
        rd(A_STATUS, v); chk(v == 32'h4, "R8 nothing stored", v, 32'h4);
        wr(A_ENABLE, 0);

        // R7 stall on empty transmit queue
        wr(A_CTRL, 0); wr(A_FRAMES, 1); rx_on = 1;
        push_tx(8'h11);
        f0 = n_frames;
        wr(A_ENABLE, 1);
        repeat (150) @(posedge clk);
        rd(A_STATUS, v); chk(v[0] == 1'b1, "R7 busy while parked", v, 1);
        chk(sclk == 1'b0, "R7 clock parked low", sclk, 0);
        chk(n_frames - f0 == 1, "R7 one frame done", n_frames - f0, 1);
        push_tx(8'h22);
        wait_idle();
        chk(first_rise - t_last_wr == 40, "R7 resume delay", first_rise - t_last_wr, 40);
        rd_expect("R7 rx first", {24'h0, exp_rx.pop_front()});
        rd_expect("R7 rx second", {24'h0, exp_rx.pop_front()});
        wr(A_ENABLE, 0);

        // R13 full transmit queue drops the extra push
        wr(A_CTRL, 1); wr(A_FRAMES, 31); rx_on = 0;
        for (int i = 0; i < 32; i++) push_tx(8'(i * 7 + 1));
        rd(A_STATUS, v); chk(v[1] == 1'b1, "R13 full flag", v, 32'h6);
        wr(A_DATA, 32'hEE);
        wr(A_ENABLE, 1);
        wait_idle();
        chk(exp_mosi.size() == 0, "R13 queue drained", exp_mosi.size(), 0);
        rd(A_STATUS, v); chk(v[1] == 1'b0, "R13 full cleared", v, 32'h4);
        wr(A_ENABLE, 0);
        wr(A_FRAMES, 0);
        push_tx(8'h5A);
        wr(A_ENABLE, 1);
        wait_idle();
        chk(exp_mosi.size() == 0, "R13 dropped byte absent", exp_mosi.size(), 0);
        wr(A_ENABLE, 0);

        // R12 abort mid-burst
        chk_mosi = 0; chk_timing = 0;
        wr(A_CTRL, 0); wr(A_FRAMES, 9);
        for (int i = 0; i < 10; i++) wr(A_DATA, 32'h0F);
        wr(A_ENABLE, 1);
        repeat (100) @(posedge clk);
        wr(A_ENABLE, 0);
        chk(sclk == 1'b0, "R12 clock low", sclk, 0);
        rd(A_STATUS, v); chk(v[0] == 1'b0, "R12 busy cleared", v, 0);
        f0 = n_frames;
        repeat (300) @(posedge clk);
        chk(n_frames == f0, "R12 no more frames", n_frames - f0, 0);
        wr(A_SELECT, 0);
        chk(cs_n == 1'b1, "R11 release", cs_n, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule